// File: doc/BRIEF.md
# Configurable UART Frame Transmitter

This block turns one parallel character into one asynchronous serial frame on a single output line. A character is handed over through a valid/ready handshake. At the moment of hand-over, an eight-bit line-control byte is captured alongside it, and that byte fixes the shape of the frame. The control byte sets the word length (5 to 8 data bits). It sets the parity mode: none, odd, even, constant one or constant zero. It also sets the stop period: one, one and a half, or two bit times.

Bit timing comes from an external strobe that pulses sixteen times per bit period. The block counts these strobes itself and needs no baud divider. Each frame starts with a low start bit. The data bits follow, least significant first, then the optional parity bit, then a high stop period. Between frames the line rests high, and a busy flag shows when a frame is on the line.

Top module: `uart_frame_tx`

## Requirements
- R1: After reset, and whenever no frame is in progress, `txd` is 1, `busy` is 0 and `tx_ready` is 1, even while `tick16` keeps pulsing.
- R2: A character is taken on a clock edge where `tx_valid` and `tx_ready` are both 1. From the next cycle, `busy` is 1 and `tx_ready` is 0 until the frame ends, and a `tx_valid` raised during that time is not taken.
- R3: Each frame bit lasts 16 `tick16` pulses. The start bit is 0, and the data bits follow least significant first. The word length is 5, 6, 7 or 8, selected by control bits [1:0] = 00, 01, 10, 11.
- R4: With control bit 3 at 0, no parity bit is sent, whatever control bits 5 and 4 hold.
- R5: With control bit 3 at 1 and bit 5 at 0, a parity bit follows the data. Bit 4 = 0 makes the number of ones over data plus parity odd. Bit 4 = 1 makes that number even.
- R6: With control bits 3 and 5 at 1, the parity bit is a constant. It is 1 when bit 4 is 0 and 0 when bit 4 is 1.
- R7: With control bit 2 at 0, the stop period is high for 16 pulses. `busy` falls on the clock edge that consumes the last stop pulse.
- R8: With control bit 2 at 1, the stop period lasts 24 pulses for 5-bit characters and 32 pulses for 6, 7 or 8-bit characters.
- R9: The control byte is captured when a character is taken. Changing `line_ctrl` during a frame does not alter that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick16 | input | 1 | One-cycle strobe, sixteen per bit period |
| tx_valid | input | 1 | A character is offered |
| tx_data | input | 8 | Character; bits above the word length are ignored |
| tx_ready | output | 1 | The block can take a character this cycle |
| line_ctrl | input | 8 | Framing control byte, captured with the character |
| txd | output | 1 | Serial line, idles high |
| busy | output | 1 | A frame is on the line |

## Verification
The line is registered, so the start bit shows in the cycle after the accepting edge. Every later bit changes on the edge that consumes the sixteenth pulse of the bit before it. The bench therefore samples `txd` on the falling edge of each cycle where `tick16` is high. Each sample is compared with the bit that the requirements place at that pulse index. `busy` must fall on the edge that consumes the last stop pulse, so the bench checks it on the falling edge just after that pulse. It also checks `busy` and `tx_ready` on every falling edge before then, which pins the frame length to the exact pulse.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

  localparam int TX_DATA_W = 8;
  localparam int TX_TPB    = 16;
  localparam int NBITS_W   = 4;
  localparam int CNT_W     = 6;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_START  = 3'd1,
    ST_DATA   = 3'd2,
    ST_PARITY = 3'd3,
    ST_STOP   = 3'd4
  } tx_state_e;

  typedef struct packed {
    logic [NBITS_W-1:0] nbits;
    logic               par_en;
    logic               par_bit;
    logic [CNT_W-1:0]   stop_ticks;
  } frame_cfg_t;

endpackage

// File: rtl/uart_tx_ctrl_dec.sv
module uart_tx_ctrl_dec
  import uart_tx_pkg::*;
#(
  parameter int TICKS_PER_BIT = TX_TPB
) (
  input  logic [7:0]           ctrl_i,
  input  logic [TX_DATA_W-1:0] data_i,
  output frame_cfg_t           cfg_o
);

  localparam int HALF_TICKS = TICKS_PER_BIT / 2;

  logic [NBITS_W-1:0]   nbits;
  logic [TX_DATA_W-1:0] data_used;
  logic                 ones_odd;

  assign nbits = NBITS_W'(5) + NBITS_W'(ctrl_i[1:0]);

  for (genvar i = 0; i < TX_DATA_W; i++) begin : g_mask
    assign data_used[i] = data_i[i] & (NBITS_W'(i) < nbits);
  end

  assign ones_odd = ^data_used;

  always_comb begin
    cfg_o.nbits  = nbits;
    cfg_o.par_en = ctrl_i[3];
    if (ctrl_i[5]) begin
      cfg_o.par_bit = ~ctrl_i[4];
    end else if (ctrl_i[4]) begin
      cfg_o.par_bit = ones_odd;
    end else begin
      cfg_o.par_bit = ~ones_odd;
    end
    if (!ctrl_i[2]) begin
      cfg_o.stop_ticks = CNT_W'(TICKS_PER_BIT);
    end else if (ctrl_i[1:0] == 2'b00) begin
      cfg_o.stop_ticks = CNT_W'(TICKS_PER_BIT + HALF_TICKS);
    end else begin
      cfg_o.stop_ticks = CNT_W'(2 * TICKS_PER_BIT);
    end
  end

endmodule

// File: rtl/uart_tx_bit_timer.sv
module uart_tx_bit_timer
  import uart_tx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             done_o
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  assign done_o = run_i && tick_i && (cnt_q == limit_i - CNT_W'(1));

  always_comb begin
    cnt_d = cnt_q;
    if (!run_i || done_o) begin
      cnt_d = '0;
    end else if (tick_i) begin
      cnt_d = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  AST_CNT_BELOW_LIMIT: assert property (@(posedge clk) disable iff (!rst_ni)
    run_i |-> (cnt_q < limit_i)) else $error("tick count past period"); // R8

endmodule

// File: rtl/uart_frame_tx.sv
module uart_frame_tx
  import uart_tx_pkg::*;
#(
  parameter int TICKS_PER_BIT = TX_TPB
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick16,
  input  logic                 tx_valid,
  input  logic [TX_DATA_W-1:0] tx_data,
  output logic                 tx_ready,
  input  logic [7:0]           line_ctrl,
  output logic                 txd,
  output logic                 busy
);

  logic [1:0] rst_pipe_q;
  logic       rst_sn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= 2'b00;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end
  assign rst_sn = rst_pipe_q[1];

  tx_state_e            state_q, state_d;
  frame_cfg_t           cfg_q, cfg_d, cfg_new;
  logic [TX_DATA_W-1:0] shift_q, shift_d;
  logic [NBITS_W-1:0]   left_q, left_d;
  logic                 txd_q, txd_d;
  logic                 accept;
  logic                 bit_done;
  logic                 running;
  logic [CNT_W-1:0]     period;

  uart_tx_ctrl_dec #(.TICKS_PER_BIT(TICKS_PER_BIT)) u_dec (
    .ctrl_i (line_ctrl),
    .data_i (tx_data),
    .cfg_o  (cfg_new)
  );

  assign running = (state_q != ST_IDLE);
  assign period  = (state_q == ST_STOP) ? cfg_q.stop_ticks : CNT_W'(TICKS_PER_BIT);

  uart_tx_bit_timer u_timer (
    .clk     (clk),
    .rst_ni  (rst_sn),
    .run_i   (running),
    .tick_i  (tick16),
    .limit_i (period),
    .done_o  (bit_done)
  );

  assign tx_ready = rst_sn && (state_q == ST_IDLE);
  assign accept   = tx_valid && tx_ready;
  assign busy     = running;
  assign txd      = txd_q;

  always_comb begin
    state_d = state_q;
    cfg_d   = cfg_q;
    shift_d = shift_q;
    left_d  = left_q;
    txd_d   = txd_q;
    unique case (state_q)
      ST_IDLE: begin
        txd_d = 1'b1;
        if (accept) begin
          state_d = ST_START;
          cfg_d   = cfg_new;
          shift_d = tx_data;
          txd_d   = 1'b0;
        end
      end
      ST_START: begin
        if (bit_done) begin
          state_d = ST_DATA;
          txd_d   = shift_q[0];
          left_d  = cfg_q.nbits - NBITS_W'(1);
        end
      end
      ST_DATA: begin
        if (bit_done) begin
          if (left_q != '0) begin
            shift_d = shift_q >> 1;
            txd_d   = shift_q[1];
            left_d  = left_q - NBITS_W'(1);
          end else if (cfg_q.par_en) begin
            state_d = ST_PARITY;
            txd_d   = cfg_q.par_bit;
          end else begin
            state_d = ST_STOP;
            txd_d   = 1'b1;
          end
        end
      end
      ST_PARITY: begin
        if (bit_done) begin
          state_d = ST_STOP;
          txd_d   = 1'b1;
        end
      end
      ST_STOP: begin
        if (bit_done) begin
          state_d = ST_IDLE;
        end
      end
      default: begin
        state_d = ST_IDLE;
        txd_d   = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      state_q <= ST_IDLE;
      cfg_q   <= '0;
      shift_q <= '0;
      left_q  <= '0;
      txd_q   <= 1'b1;
    end else begin
      state_q <= state_d;
      cfg_q   <= cfg_d;
      shift_q <= shift_d;
      left_q  <= left_d;
      txd_q   <= txd_d;
    end
  end

  AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_sn)
    (state_q == ST_IDLE) |-> txd_q) else $error("line low while idle"); // R1

  AST_ACCEPT_STARTS: assert property (@(posedge clk) disable iff (!rst_sn)
    (tx_valid && tx_ready) |=> (busy && !txd)) else $error("no start bit after accept"); // R2

  AST_PARITY_ONLY_ENABLED: assert property (@(posedge clk) disable iff (!rst_sn)
    (state_q == ST_PARITY) |-> cfg_q.par_en) else $error("parity sent while disabled"); // R4

  AST_STOP_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_sn)
    (state_q == ST_STOP) |-> txd_q) else $error("line low in stop period"); // R7

  AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_sn)
    (busy && $past(busy)) |-> $stable(cfg_q)) else $error("framing changed mid-frame"); // R9

endmodule

// File: tb/uart_frame_tx_bench.sv
module uart_frame_tx_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick16 = 1'b0;
  logic       tx_valid = 1'b0;
  logic [7:0] tx_data = 8'h00;
  logic [7:0] line_ctrl = 8'h00;
  logic       tx_ready;
  logic       txd;
  logic       busy;
  logic [1:0] tdiv = 2'd0;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  always @(posedge clk) begin
    tdiv   <= tdiv + 2'd1;
    tick16 <= (tdiv == 2'd3);
  end

  uart_frame_tx u_uart_frame_tx (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick16    (tick16),
    .tx_valid  (tx_valid),
    .tx_data   (tx_data),
    .tx_ready  (tx_ready),
    .line_ctrl (line_ctrl),
    .txd       (txd),
    .busy      (busy)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int nbits_of(input logic [7:0] c);
    return 5 + int'(c[1:0]);
  endfunction

  function automatic logic par_of(input logic [7:0] d, input logic [7:0] c);
    logic ones = 1'b0;
    for (int i = 0; i < nbits_of(c); i++) ones ^= d[i];
    if (c[5]) return ~c[4];
    return c[4] ? ones : ~ones;
  endfunction

  function automatic int total_ticks(input logic [7:0] c);
    int stop;
    stop = !c[2] ? 16 : (nbits_of(c) == 5 ? 24 : 32);
    return 16 * (1 + nbits_of(c) + int'(c[3])) + stop;
  endfunction

  function automatic logic exp_line(input int k, input logic [7:0] d, input logic [7:0] c);
    int slot;
    slot = k / 16;
    if (slot == 0) return 1'b0;
    if (slot <= nbits_of(c)) return d[slot-1];
    if (c[3] && slot == nbits_of(c) + 1) return par_of(d, c);
    return 1'b1;
  endfunction

  task automatic run_frame(input logic [7:0] d, input logic [7:0] c,
                           input logic [7:0] c_late, input int chg_at,
                           input bit hold_v, input string req);
    int total, k, bad_k, bad_act, bad_exp, side_bad;
    total = total_ticks(c);
    @(negedge clk);
    check(tx_ready === 1'b1, "R2", "ready before offer", int'(tx_ready), 1);
    tx_data   = d;
    line_ctrl = c;
    tx_valid  = 1'b1;
    @(negedge clk);
    tx_valid = 1'b0;
    k = 0; bad_k = -1; bad_act = 0; bad_exp = 0; side_bad = 0;
    while (k < total) begin
      if (!(busy === 1'b1 && tx_ready === 1'b0)) side_bad++;
      if (tick16) begin
        if (txd !== exp_line(k, d, c) && bad_k < 0) begin
          bad_k = k; bad_act = int'(txd); bad_exp = int'(exp_line(k, d, c));
        end
        if (k == chg_at) line_ctrl = c_late;
        if (hold_v && k == 5) begin tx_valid = 1'b1; tx_data = ~d; end
        if (hold_v && k == total - 2) tx_valid = 1'b0;
        k++;
      end
      @(negedge clk);
    end
    if (bad_k >= 0)
      $display("FAIL %s first bad bit at tick %0d: actual=%0d expected=%0d",
               req, bad_k, bad_act, bad_exp);
    checks++;
    if (bad_k >= 0) errors++;
    check(side_bad == 0, "R2", "cycles not busy during frame", side_bad, 0);
    check(busy === 1'b0 && tx_ready === 1'b1 && txd === 1'b1, req,
          "idle right after last stop tick (busy)", int'(busy), 0);
  endtask

  task automatic t_reset;
    check(txd === 1'b1, "R1", "txd after reset", int'(txd), 1);
    check(busy === 1'b0, "R1", "busy after reset", int'(busy), 0);
    check(tx_ready === 1'b1, "R1", "ready after reset", int'(tx_ready), 1);
    repeat (40) begin
      @(negedge clk);
      if (txd !== 1'b1 || busy !== 1'b0) begin
        check(1'b0, "R1", "line moved while idle", int'(txd), 1);
        break;
      end
    end
  endtask

  task automatic t_word_lengths;
    run_frame(8'hA5, 8'h03, 8'h03, -1, 1'b0, "R3 8N1");
    run_frame(8'hF3, 8'h00, 8'h00, -1, 1'b0, "R3 5N1");
    run_frame(8'h96, 8'h01, 8'h01, -1, 1'b0, "R3 6N1");
  endtask

  task automatic t_parity_off;
    run_frame(8'h5A, 8'h31, 8'h31, -1, 1'b0, "R4 ignore 5:4");
  endtask

  task automatic t_parity_calc;
    run_frame(8'h37, 8'h0B, 8'h0B, -1, 1'b0, "R5 odd");
    run_frame(8'h37, 8'h1B, 8'h1B, -1, 1'b0, "R5 even");
    run_frame(8'hFF, 8'h1A, 8'h1A, -1, 1'b0, "R5 even 7bit");
  endtask

  task automatic t_parity_forced;
    run_frame(8'h00, 8'h2A, 8'h2A, -1, 1'b0, "R6 mark");
    run_frame(8'hFF, 8'h3B, 8'h3B, -1, 1'b0, "R6 space");
  endtask

  task automatic t_stop_len;
    run_frame(8'h15, 8'h04, 8'h04, -1, 1'b0, "R8 1.5 stop");
    run_frame(8'hC3, 8'h07, 8'h07, -1, 1'b0, "R8 2 stop");
    run_frame(8'h2C, 8'h0D, 8'h0D, -1, 1'b0, "R8 2 stop 6bit parity");
    run_frame(8'h81, 8'h02, 8'h02, -1, 1'b0, "R7 1 stop");
  endtask

  task automatic t_mid_change;
    run_frame(8'h6B, 8'h00, 8'h3F, 20, 1'b0, "R9 ctrl change");
  endtask

  task automatic t_hold_valid;
    run_frame(8'h4E, 8'h0B, 8'h0B, -1, 1'b1, "R2 valid while busy");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: run did not end, actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_word_lengths();
    t_parity_off();
    t_parity_calc();
    t_parity_forced();
    t_stop_len();
    t_mid_change();
    t_hold_valid();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule